// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a single-bit serial flash bus made of chip select, serial clock, data out and data in. Six request inputs ask for an ID read, a read, a write, a status-register write, a sector erase or a whole-array erase. A fixed-priority arbiter picks one request at a time. The sequencer runs the ID read, the status write and both erases itself. For read and write requests it only hands the bus over to separate streaming engines, which are not part of this block.

A modifying command is always preceded by a write-enable frame. After it, the sequencer keeps polling the flash status register. A busy flag stays high until the device reports that the operation has finished. If a region is write-protected, the device never finishes, so the flag stays high until reset. The ID read is repeated while its request is held, until a recognised ID byte comes back. The erases start on the rising edge of their request.

There is no data stream crossing the block edge, so there is no valid/ready interface. All pins are plain level control and status signals. A request is taken when the sequencer is idle; none is refused or queued beyond the erase edge memory.

Top module: `flash_cmd_seq`

## Requirements
- R1: Requests are served one at a time, in this priority order from highest to lowest: ID read, read hand-off, write hand-off, status write, sector erase, bulk erase. If sector-erase and bulk-erase edges arrive together, the sector erase frames come first.
- R2: A granted read (or write) request raises `rd_grant` (or `wr_grant`) only. It keeps chip select high while the grant lasts. When the request drops, the grant ends and the sequencer goes back to idle.
- R3: An ID read is one frame of five bytes: opcode 0xAB, then three dummy 0x00 bytes, then the fifth byte, which is captured onto `id_out`.
- R4: While `req_id` is high, the ID frame is repeated until the captured byte is 0x10, 0x12, 0x14 or 0x16. After a recognised byte, no further ID frame is sent until `req_id` has dropped.
- R5: `id_out` is 0x00 after reset. It changes only when an ID frame completes, and otherwise keeps its value after the request drops.
- R6: Sector and bulk erase start on a 0-to-1 transition of their request. A level that stays high starts nothing more. An edge that arrives while other work is running is remembered and served later.
- R7: Each status write, sector erase and bulk erase begins with a one-byte frame of opcode 0x06.
- R8: The sector erase frame is 0xD8 followed by `addr[23:16]`, `addr[15:8]`, `addr[7:0]`. The bulk erase frame is the single byte 0xC7. The status write frame is 0x01 followed by `wr_data`.
- R9: After the command frame, two-byte frames of 0x05 are repeated until bit 0 of the second byte reads 0. The busy flag for the operation (`wrsr_busy`, `se_busy` or `be_busy`) is high from acceptance until that final poll. If bit 0 never clears, the flag stays high until reset.
- R10: Chip select is low for the whole of each frame and high for at least `GAP_CYC` cycles between frames. The serial clock idles low and is low whenever chip select is high. Bytes go out MSB first, change after the falling clock edge and are sampled by the sequencer on the rising edge.
- R11: A status write is level-requested. Once it has completed, it is not started again until `req_wrsr` has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_id | input | 1 | ID read request (level, retried) |
| req_read | input | 1 | Read hand-off request (level) |
| req_write | input | 1 | Write hand-off request (level) |
| req_wrsr | input | 1 | Status register write request (level) |
| req_se | input | 1 | Sector erase request (rising edge) |
| req_be | input | 1 | Bulk erase request (rising edge) |
| addr | input | ADDR_W | Sector address for erase |
| wr_data | input | 8 | New status register value |
| rd_grant | output | 1 | Bus handed to the read engine |
| wr_grant | output | 1 | Bus handed to the write engine |
| id_out | output | 8 | Last captured ID byte |
| wrsr_busy | output | 1 | Status write in progress |
| se_busy | output | 1 | Sector erase in progress |
| be_busy | output | 1 | Bulk erase in progress |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with `ADDR_W` = 24, `SCK_HALF` = 2 and `GAP_CYC` = 2. With these values, one byte takes about 35 clock cycles. This makes room in a single run for erases that need several status polls, for ID reads that retry across several frames, and for a protected erase that is left stalled for thousands of cycles before reset. The 24-bit address gives the three-byte address phase, and its byte order can be checked against random addresses.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDID = 8'hAB;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam int         ID_DUMMY = 3;

  // value order is the arbitration order (lower wins)
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ID   = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_WRSR = 3'd4,
    CMD_SE   = 3'd5,
    CMD_BE   = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    FR_ID, FR_WREN, FR_WRSR, FR_SE, FR_BE, FR_RDSR
  } frame_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_FRAME, ST_GAP
  } st_e;

  function automatic logic id_known(input logic [7:0] b);
    return (b == 8'h10) || (b == 8'h12) || (b == 8'h14) || (b == 8'h16);
  endfunction

  function automatic frame_e cmd_frame(input cmd_e c);
    case (c)
      CMD_WRSR: return FR_WRSR;
      CMD_SE:   return FR_SE;
      default:  return FR_BE;
    endcase
  endfunction

endpackage

// File: rtl/flash_req_arb.sv
module flash_req_arb
  import flash_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_id,
  input  logic req_read,
  input  logic req_write,
  input  logic req_wrsr,
  input  logic req_se,
  input  logic req_be,
  input  logic id_hold,
  input  logic wrsr_hold,
  input  logic accept,
  output cmd_e pick
);
  localparam int NREQ = 6;

  logic se_d, be_d, se_pend, be_pend;
  logic [NREQ-1:0] rv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      se_d    <= 1'b0;
      be_d    <= 1'b0;
      se_pend <= 1'b0;
      be_pend <= 1'b0;
    end else begin
      se_d <= req_se;
      be_d <= req_be;
      if (req_se && !se_d)                  se_pend <= 1'b1;
      else if (accept && pick == CMD_SE)    se_pend <= 1'b0;
      if (req_be && !be_d)                  be_pend <= 1'b1;
      else if (accept && pick == CMD_BE)    be_pend <= 1'b0;
    end
  end

  assign rv = {be_pend, se_pend, req_wrsr & ~wrsr_hold,
               req_write, req_read, req_id & ~id_hold};

  always_comb begin
    pick = CMD_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (rv[i]) pick = cmd_e'(3'(i + 1));
    end
  end

  // R6
  se_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(se_pend) |-> $past(req_se));
  // R1
  be_after_se_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == CMD_BE) |-> !se_pend);

endmodule

// File: rtl/flash_byte_shift.sv
module flash_byte_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sh   <= tx;
        mosi <= tx[7];
        cnt  <= '0;
        bitn <= '0;
        sck  <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(HALF - 1)) begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R10
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mosi)) |-> $fell(sck));

endmodule

// File: rtl/flash_frame_bytes.sv
module flash_frame_bytes
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 3
) (
  input  frame_e              kind,
  input  logic [IDX_W-1:0]    idx,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          tx_byte,
  output logic                last
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [IDX_W-1:0] len;

  always_comb begin
    tx_byte = 8'h00;
    len     = IDX_W'(1);
    case (kind)
      FR_ID: begin
        len = IDX_W'(ID_DUMMY + 2);
        if (idx == '0) tx_byte = OP_RDID;
      end
      FR_WREN: tx_byte = OP_WREN;
      FR_WRSR: begin
        len     = IDX_W'(2);
        tx_byte = (idx == '0) ? OP_WRSR : wdata;
      end
      FR_SE: begin
        len = IDX_W'(ADDR_BYTES + 1);
        if (idx == '0) tx_byte = OP_SE;
        for (int k = 1; k <= ADDR_BYTES; k++) begin
          if (idx == IDX_W'(k)) tx_byte = addr[(ADDR_BYTES - k) * 8 +: 8];
        end
      end
      FR_BE: tx_byte = OP_BE;
      default: begin
        len = IDX_W'(2);
        if (idx == '0) tx_byte = OP_RDSR;
      end
    endcase
  end

  assign last = (idx == len - IDX_W'(1));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SCK_HALF = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_id,
  input  logic              req_read,
  input  logic              req_write,
  input  logic              req_wrsr,
  input  logic              req_se,
  input  logic              req_be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic              rd_grant,
  output logic              wr_grant,
  output logic [7:0]        id_out,
  output logic              wrsr_busy,
  output logic              se_busy,
  output logic              be_busy,
  output logic              flash_cs_n,
  output logic              flash_sck,
  output logic              flash_mosi,
  input  logic              flash_miso
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ID_LEN     = ID_DUMMY + 2;
  localparam int MAX_LEN    = (ADDR_BYTES + 1 > ID_LEN) ? ADDR_BYTES + 1 : ID_LEN;
  localparam int IDX_W      = $clog2(MAX_LEN + 1);
  localparam int GAP_W      = $clog2(GAP_CYC + 1);

  st_e              state;
  cmd_e             pick, cur_cmd;
  frame_e           frame, nxt_frame;
  logic             nxt_idle, launch, accept;
  logic [IDX_W-1:0] byte_idx;
  logic [GAP_W-1:0] gap_cnt;
  logic             id_hold, wrsr_hold;
  logic [7:0]       id_q, tx_byte, sh_rx;
  logic             frm_last, sh_busy, sh_done, cs_q;
  logic             wrsr_q, se_q, be_q;

  flash_req_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_id    (req_id),
    .req_read  (req_read),
    .req_write (req_write),
    .req_wrsr  (req_wrsr),
    .req_se    (req_se),
    .req_be    (req_be),
    .id_hold   (id_hold),
    .wrsr_hold (wrsr_hold),
    .accept    (accept),
    .pick      (pick)
  );

  flash_frame_bytes #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bytes (
    .kind    (frame),
    .idx     (byte_idx),
    .addr    (addr),
    .wdata   (wr_data),
    .tx_byte (tx_byte),
    .last    (frm_last)
  );

  flash_byte_shift #(.HALF(SCK_HALF)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .tx    (tx_byte),
    .miso  (flash_miso),
    .sck   (flash_sck),
    .mosi  (flash_mosi),
    .busy  (sh_busy),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  assign accept = (state == ST_IDLE) && (pick != CMD_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_cmd   <= CMD_NONE;
      frame     <= FR_WREN;
      nxt_frame <= FR_WREN;
      nxt_idle  <= 1'b1;
      launch    <= 1'b0;
      byte_idx  <= '0;
      gap_cnt   <= '0;
      cs_q      <= 1'b1;
      id_q      <= 8'h00;
      id_hold   <= 1'b0;
      wrsr_hold <= 1'b0;
      wrsr_q    <= 1'b0;
      se_q      <= 1'b0;
      be_q      <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (!req_id)   id_hold   <= 1'b0;
      if (!req_wrsr) wrsr_hold <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_cmd <= pick;
            case (pick)
              CMD_RD: state <= ST_RD;
              CMD_WR: state <= ST_WR;
              default: begin
                frame    <= (pick == CMD_ID) ? FR_ID : FR_WREN;
                byte_idx <= '0;
                cs_q     <= 1'b0;
                launch   <= 1'b1;
                state    <= ST_FRAME;
                if (pick == CMD_WRSR) wrsr_q <= 1'b1;
                if (pick == CMD_SE)   se_q   <= 1'b1;
                if (pick == CMD_BE)   be_q   <= 1'b1;
              end
            endcase
          end
        end
        ST_RD: if (!req_read)  state <= ST_IDLE;
        ST_WR: if (!req_write) state <= ST_IDLE;
        ST_FRAME: begin
          if (sh_done) begin
            if (!frm_last) begin
              byte_idx <= byte_idx + IDX_W'(1);
              launch   <= 1'b1;
            end else begin
              cs_q    <= 1'b1;
              gap_cnt <= '0;
              state   <= ST_GAP;
              case (frame)
                FR_ID: begin
                  id_q <= sh_rx;
                  if (id_known(sh_rx) || !req_id) begin
                    nxt_idle <= 1'b1;
                    if (req_id) id_hold <= 1'b1;
                  end else begin
                    nxt_idle  <= 1'b0;
                    nxt_frame <= FR_ID;
                  end
                end
                FR_WREN: begin
                  nxt_idle  <= 1'b0;
                  nxt_frame <= cmd_frame(cur_cmd);
                end
                FR_RDSR: begin
                  if (!sh_rx[0]) begin
                    nxt_idle <= 1'b1;
                    wrsr_q   <= 1'b0;
                    se_q     <= 1'b0;
                    be_q     <= 1'b0;
                    if (cur_cmd == CMD_WRSR && req_wrsr) wrsr_hold <= 1'b1;
                  end else begin
                    nxt_idle  <= 1'b0;
                    nxt_frame <= FR_RDSR;
                  end
                end
                default: begin
                  nxt_idle  <= 1'b0;
                  nxt_frame <= FR_RDSR;
                end
              endcase
            end
          end
        end
        default: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            if (nxt_idle) begin
              state   <= ST_IDLE;
              cur_cmd <= CMD_NONE;
            end else begin
              frame    <= nxt_frame;
              byte_idx <= '0;
              cs_q     <= 1'b0;
              launch   <= 1'b1;
              state    <= ST_FRAME;
            end
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
      endcase
    end
  end

  assign rd_grant   = (state == ST_RD);
  assign wr_grant   = (state == ST_WR);
  assign id_out     = id_q;
  assign wrsr_busy  = wrsr_q;
  assign se_busy    = se_q;
  assign be_busy    = be_q;
  assign flash_cs_n = cs_q;

  // R10
  cs_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);
  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n) |=> flash_cs_n);
  // R2
  grant_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant || wr_grant) |-> (flash_cs_n && !(rd_grant && wr_grant)));
  // R9
  busy_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrsr_busy, se_busy, be_busy}));
  // R5
  id_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_out) |-> $past(sh_done));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_id = 0, req_read = 0, req_write = 0, req_wrsr = 0, req_se = 0, req_be = 0;
  logic [23:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic rd_grant, wr_grant, wrsr_busy, se_busy, be_busy;
  logic flash_cs_n, flash_sck, flash_mosi;
  logic flash_miso = 1'b0;
  logic [7:0] id_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(24), .SCK_HALF(2), .GAP_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_id(req_id), .req_read(req_read),
    .req_write(req_write), .req_wrsr(req_wrsr), .req_se(req_se), .req_be(req_be),
    .addr(addr), .wr_data(wr_data), .rd_grant(rd_grant), .wr_grant(wr_grant),
    .id_out(id_out), .wrsr_busy(wrsr_busy), .se_busy(se_busy), .be_busy(be_busy),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_mosi(flash_mosi),
    .flash_miso(flash_miso)
  );

  // ---------------- behavioural flash ----------------
  logic [7:0] m_id = 8'h14;
  int   m_bad = 0;
  int   m_polls = 1;
  bit   m_protect = 0;
  bit   m_wip = 0;
  int   m_left = 0;
  int   bitc = 0;
  logic [7:0] shreg = 0;
  logic [7:0] cur [0:5];
  logic [7:0] log_b [0:63][0:5];
  int   log_len [0:63];
  int   nfr = 0;
  int   sck_while_high = 0;

  function automatic logic [7:0] resp_byte(input int k);
    if (cur[0] == 8'hAB && k >= 4) return (m_bad > 0) ? 8'h3C : m_id;
    if (cur[0] == 8'h05 && k >= 1) return {7'b0, m_wip};
    return 8'h00;
  endfunction

  always @(posedge flash_sck or posedge flash_cs_n) begin
    if (flash_cs_n) begin
      if (bitc > 0) begin
        if (nfr < 64) begin
          for (int b = 0; b < 6; b++) log_b[nfr][b] = cur[b];
          log_len[nfr] = bitc / 8;
        end
        nfr++;
        if ((cur[0] == 8'hD8 || cur[0] == 8'hC7 || cur[0] == 8'h01)) begin
          m_wip = 1; m_left = m_polls;
        end else if (cur[0] == 8'h05 && m_wip && !m_protect) begin
          m_left--; if (m_left <= 0) m_wip = 0;
        end else if (cur[0] == 8'hAB && m_bad > 0) begin
          m_bad--;
        end
      end
      bitc = 0;
      for (int b = 0; b < 6; b++) cur[b] = 8'h00;
    end else begin
      shreg = {shreg[6:0], flash_mosi};
      bitc++;
      if (bitc % 8 == 0 && bitc / 8 <= 6) cur[bitc/8 - 1] = shreg;
    end
  end

  always @(negedge flash_sck or negedge flash_cs_n) begin
    if (!flash_cs_n) begin
      logic [7:0] rb;
      rb = resp_byte(bitc / 8);
      flash_miso = rb[7 - (bitc % 8)];
    end
  end

  always @(posedge clk) if (rst_n && flash_cs_n && flash_sck) sck_while_high++;

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet(input int lim);
    int n = 0;
    cyc(4);
    while ((wrsr_busy || se_busy || be_busy || !flash_cs_n) && n < lim) begin
      @(negedge clk); n++;
    end
    cyc(20);
  endtask

  function automatic logic [7:0] pick_id(input int k);
    return 8'h10 + 8'(2 * (k % 4));
  endfunction

  function automatic int exp_frames(input int polls);
    return polls + 3; // wren, command, polls+1 status reads
  endfunction

  task automatic do_reset();
    rst_n = 0; cyc(5); rst_n = 1; cyc(2);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    // R5 R10 reset state
    chk("R5 id after reset", id_out, 8'h00);
    chk("R10 cs idle", flash_cs_n, 1'b1);
    chk("R10 sck idle", flash_sck, 1'b0);
    chk("R9 busy idle", {wrsr_busy, se_busy, be_busy}, 3'b000);
    chk("R2 grants idle", {rd_grant, wr_grant}, 2'b00);

    // R3 plain ID read, held request
    m_id = 8'h14; m_bad = 0; nfr = 0;
    req_id = 1; cyc(600);
    chk("R3 id captured", id_out, 8'h14);
    chk("R4 no repeat after known id", nfr, 1);
    chk("R3 id opcode", log_b[0][0], 8'hAB);
    chk("R3 id dummies", {log_b[0][1], log_b[0][2], log_b[0][3]}, 24'h0);
    chk("R3 id frame length", log_len[0], 5);
    req_id = 0; cyc(50);
    chk("R5 id held after drop", id_out, 8'h14);

    // R4 retry with random bad count and id
    for (int t = 0; t < 2; t++) begin
      int bad;
      bad = 1 + int'($urandom_range(2));
      m_bad = bad; m_id = pick_id(int'($urandom_range(3))); nfr = 0;
      req_id = 1; cyc(200 * (bad + 2));
      chk("R4 retry frame count", nfr, bad + 1);
      chk("R4 recognised id", id_out, m_id);
      req_id = 0; cyc(10);
    end

    // R6 R7 R8 R9 sector erase, random addresses and poll counts
    for (int t = 0; t < 3; t++) begin
      logic [23:0] a;
      a = 24'($urandom); m_polls = 1 + int'($urandom_range(3));
      addr = a; nfr = 0;
      req_se = 1; cyc(3);
      chk("R9 se busy raised", se_busy, 1'b1);
      if (t != 0) req_se = 0;
      wait_quiet(5000);
      chk("R9 se busy cleared", se_busy, 1'b0);
      chk("R9 se frame count", nfr, exp_frames(m_polls));
      chk("R7 wren before se", {log_b[0][0], 8'(log_len[0])}, {8'h06, 8'd1});
      chk("R8 se opcode+addr", {log_b[1][0], log_b[1][1], log_b[1][2], log_b[1][3]},
          {8'hD8, a});
      chk("R9 poll opcode", {log_b[2][0], 8'(log_len[2])}, {8'h05, 8'd2});
      if (t == 0) begin
        cyc(400);
        chk("R6 held level no rerun", nfr, exp_frames(m_polls));
        req_se = 0; cyc(5);
      end
    end

    // R8 bulk erase
    m_polls = 2; nfr = 0;
    req_be = 1; cyc(3); req_be = 0;
    wait_quiet(5000);
    chk("R8 be opcode", {log_b[1][0], 8'(log_len[1])}, {8'hC7, 8'd1});
    chk("R9 be frames", nfr, exp_frames(2));

    // R11 status write, level held past completion
    wr_data = 8'($urandom); m_polls = 1; nfr = 0;
    req_wrsr = 1; cyc(3);
    chk("R9 wrsr busy", wrsr_busy, 1'b1);
    wait_quiet(5000);
    chk("R8 wrsr frame", {log_b[1][0], log_b[1][1]}, {8'h01, wr_data});
    chk("R7 wren before wrsr", log_b[0][0], 8'h06);
    cyc(400);
    chk("R11 no rerun while held", nfr, exp_frames(1));
    req_wrsr = 0; cyc(5);

    // R1 sector vs bulk edges together, and ID vs sector erase
    m_polls = 1; nfr = 0; addr = 24'h0A0B0C;
    req_se = 1; req_be = 1; cyc(3); req_se = 0; req_be = 0;
    wait_quiet(5000); wait_quiet(5000);
    chk("R1 se before be", {log_b[1][0], log_b[5][0]}, {8'hD8, 8'hC7});
    m_id = 8'h16; m_bad = 0; nfr = 0;
    req_id = 1; req_se = 1; cyc(3); req_se = 0;
    wait_quiet(5000); cyc(800); wait_quiet(5000);
    chk("R1 id first", log_b[0][0], 8'hAB);
    chk("R6 edge remembered", log_b[2][0], 8'hD8);
    req_id = 0; cyc(5);

    // R2 R1 hand-off grants
    req_read = 1; req_write = 1; req_wrsr = 1; cyc(4);
    chk("R2 read granted", {rd_grant, wr_grant, flash_cs_n}, 3'b101);
    req_read = 0; cyc(4);
    chk("R1 write over wrsr", {wr_grant, wrsr_busy}, 2'b10);
    req_write = 0; req_wrsr = 0; cyc(4);
    chk("R2 grants released", {rd_grant, wr_grant}, 2'b00);
    wait_quiet(5000);

    // R9 protected bulk erase stalls until reset
    m_protect = 1; nfr = 0;
    req_be = 1; cyc(3); req_be = 0; cyc(4000);
    chk("R9 protected busy stays", be_busy, 1'b1);
    chk("R9 still polling", (nfr > 20), 1'b1);
    do_reset(); m_protect = 0; m_wip = 0;
    chk("R9 reset clears busy", be_busy, 1'b0);
    chk("R5 reset clears id", id_out, 8'h00);
    chk("R10 no sck while cs high", sck_while_high, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule